// File: doc/BRIEF.md
# Memory Write-Then-Readback Test Host

This block is a self-contained test master for a memory-mapped slave port of the kind found at the front of an SDRAM controller. After a start pulse it writes a known pattern to a small block of consecutive word addresses beginning at zero. It then reads the same block back and checks every returned word against the pattern. The result is reported on plain status pins: a done flag, a pass flag, a sticky fail flag, and the address of the first word that came back wrong.

The slave port is treated as a request stream. Chipselect acts as the valid signal, and the inverse of the slave's wait request acts as ready. A request is transferred in any cycle where chipselect is high and wait request is low. Wait request may stay high for any number of cycles, and its length may differ between reads and writes. While it is high, the host keeps the whole request (address, write data, strobes) frozen, and it never withdraws a request it has raised. Read responses come back on a separate flow with no back-pressure, marked by a read-valid pulse. The host can have up to `DEPTH` reads in flight. It remembers the address of each read in issue order, so every response is matched to the right address.

Top module: `memtest_host`

## Requirements
- R1: While reset (synchronous, active low) is sampled low, both strobes are high, chipselect is low and done, pass and fail are low after the next edge. A start pulse sampled while idle makes the write strobe go low in the very next cycle.
- R2: The write phase issues exactly `N_WORDS` writes to addresses 0, 1, … `N_WORDS-1` in that order. The data of each write is its address index in the low bits and zero above. The active-low byte enables are driven all zero, which enables every byte.
- R3: After the last write is accepted, the host reads addresses 0 … `N_WORDS-1` in ascending order, exactly once each.
- R4: While chipselect and wait request are both high, the next cycle keeps chipselect high and leaves address, write data and both strobes unchanged. The host moves on to a new request only after a cycle where wait request is low.
- R5: Read and write strobes are never low together, and chipselect is high exactly when one strobe is low.
- R6: Read data is taken only in cycles where read-valid is high. A read-valid pulse arriving with no read outstanding has no effect on done, pass or fail.
- R7: No more than `DEPTH` reads are ever outstanding. Reads may be issued back to back, so the host reaches `DEPTH` outstanding when responses are slow.
- R8: On the first returned word that differs from its expected pattern, fail rises and fail_addr captures that word's address. Later mismatches do not change fail_addr.
- R9: Done rises once all `N_WORDS` responses have returned. Pass is high exactly when done is high and no mismatch occurred, so pass and fail are never high together.
- R10: A start pulse during a pass in progress is ignored. A start pulse while idle or done clears done, pass, fail and fail_addr and runs a new pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Begin a write-then-readback pass (one-cycle pulse) |
| agt_addr | output | ADDR_W (25) | Word address of the current request |
| agt_wdata | output | DATA_W (16) | Write data of the current request |
| agt_rd_n | output | 1 | Read strobe, active low |
| agt_wr_n | output | 1 | Write strobe, active low |
| agt_cs | output | 1 | Chipselect, high while a request is presented (valid) |
| agt_be_n | output | DATA_W/8 (2) | Byte enables, active low, held at zero |
| agt_wait | input | 1 | Slave wait request (inverse of ready) |
| agt_rdata | input | DATA_W (16) | Read response data |
| agt_rdvalid | input | 1 | Read response valid |
| done | output | 1 | All readback responses received |
| pass | output | 1 | Done with no mismatch |
| fail | output | 1 | A mismatch has been seen in this pass |
| fail_addr | output | ADDR_W (25) | Address of the first mismatching word |

## Verification
If the issue index is off, the slave sees an out-of-order or repeated address on the first accepted transfer after the fault, in the same cycle. The slave model counts such transfers, and the bench checks its memory contents when the pass ends. If the expected-address queue is wrong, its head no longer matches the response, so fail rises on the next read-valid pulse with a fail_addr that differs from the first corrupted address. The bench derives that address arithmetically from the corruption mask. A wrong outstanding count shows up as more reads in flight than `DEPTH`, or as a host that stops issuing and never raises done, which the per-pass timeout reports.

// File: rtl/memtest_pkg.sv
package memtest_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WRITE = 2'd1,
    PH_READ  = 2'd2
  } phase_e;
endpackage

// File: rtl/memtest_issue.sv
// Request issue engine: walks the write phase, then the read phase,
// holding each request until the slave accepts it.
module memtest_issue
  import memtest_pkg::*;
#(
  parameter int N_WORDS = 8,
  parameter int DEPTH   = 4,
  localparam int IDX_W  = $clog2(N_WORDS + 1),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             done_i,
  input  logic             agt_wait,
  input  logic [CNT_W-1:0] q_count,
  input  logic             q_pop,
  output logic             req_active,
  output logic             req_wr,
  output logic [IDX_W-1:0] req_idx,
  output logic             start_acc,
  output logic             rd_acc
);
  phase_e           phase;
  logic             accept;
  logic [IDX_W-1:0] idx_adv;
  logic             all_issued;
  logic [CNT_W:0]   occ_next;

  always_comb begin
    start_acc  = start && ((phase == PH_IDLE) || done_i);
    accept     = req_active && !agt_wait;
    rd_acc     = accept && !req_wr;
    idx_adv    = accept ? req_idx + IDX_W'(1) : req_idx;
    all_issued = (idx_adv == IDX_W'(N_WORDS));
    occ_next   = {1'b0, q_count} + (CNT_W+1)'(rd_acc) - (CNT_W+1)'(q_pop);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase      <= PH_IDLE;
      req_active <= 1'b0;
      req_wr     <= 1'b0;
      req_idx    <= '0;
    end else if (start_acc) begin
      phase      <= PH_WRITE;
      req_active <= 1'b1;
      req_wr     <= 1'b1;
      req_idx    <= '0;
    end else begin
      case (phase)
        PH_WRITE: begin
          if (accept) begin
            if (all_issued) begin
              phase      <= PH_READ;
              req_wr     <= 1'b0;
              req_idx    <= '0;
              req_active <= 1'b1;
            end else begin
              req_idx <= idx_adv;
            end
          end
        end
        PH_READ: begin
          if (done_i) begin
            phase      <= PH_IDLE;
            req_active <= 1'b0;
          end else if (!req_active || accept) begin
            req_idx    <= idx_adv;
            req_active <= !all_issued && (occ_next < (CNT_W+1)'(DEPTH));
          end
        end
        default: begin
          req_active <= 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/memtest_tagq.sv
// In-order queue of the word indices of reads in flight.
module memtest_tagq #(
  parameter int W      = 4,
  parameter int DEPTH  = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     head,
  output logic [CNT_W-1:0] count,
  output logic             empty
);
  logic [W-1:0]     store [DEPTH];
  logic [PTR_W-1:0] wp, rp;
  logic             push_ok, pop_ok;

  always_comb begin
    empty   = (count == '0);
    push_ok = push && (count != CNT_W'(DEPTH));
    pop_ok  = pop && !empty;
    head    = store[rp];
  end

  always_ff @(posedge clk) begin
    if (push_ok) store[wp] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      if (push_ok) wp <= (wp == PTR_W'(DEPTH-1)) ? '0 : wp + PTR_W'(1);
      if (pop_ok)  rp <= (rp == PTR_W'(DEPTH-1)) ? '0 : rp + PTR_W'(1);
      count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
    end
  end
endmodule

// File: rtl/memtest_check.sv
// Compares each response with the pattern of its address and keeps status.
module memtest_check #(
  parameter int ADDR_W  = 25,
  parameter int DATA_W  = 16,
  parameter int N_WORDS = 8,
  localparam int IDX_W  = $clog2(N_WORDS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              pop,
  input  logic [IDX_W-1:0]  head_idx,
  input  logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  logic [IDX_W-1:0]  ret_cnt;
  logic [DATA_W-1:0] expect_w;
  logic              mismatch;

  always_comb begin
    expect_w = DATA_W'(head_idx);
    mismatch = pop && (rdata != expect_w);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      ret_cnt   <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
      fail_addr <= '0;
    end else begin
      if (pop) begin
        ret_cnt <= ret_cnt + IDX_W'(1);
        if (ret_cnt == IDX_W'(N_WORDS-1)) done <= 1'b1;
      end
      if (mismatch && !fail) begin
        fail      <= 1'b1;
        fail_addr <= ADDR_W'(head_idx);
      end
    end
  end
endmodule

// File: rtl/memtest_host.sv
module memtest_host #(
  parameter int ADDR_W  = 25,
  parameter int DATA_W  = 16,
  parameter int N_WORDS = 8,
  parameter int DEPTH   = 4,
  localparam int BE_W   = DATA_W / 8,
  localparam int IDX_W  = $clog2(N_WORDS + 1),
  localparam int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  output logic [ADDR_W-1:0] agt_addr,
  output logic [DATA_W-1:0] agt_wdata,
  output logic              agt_rd_n,
  output logic              agt_wr_n,
  output logic              agt_cs,
  output logic [BE_W-1:0]   agt_be_n,
  input  logic              agt_wait,
  input  logic [DATA_W-1:0] agt_rdata,
  input  logic              agt_rdvalid,
  output logic              done,
  output logic              pass,
  output logic              fail,
  output logic [ADDR_W-1:0] fail_addr
);
  logic             req_active, req_wr, start_acc, rd_acc;
  logic [IDX_W-1:0] req_idx, head_idx;
  logic [CNT_W-1:0] q_count;
  logic             q_empty, q_pop;

  assign q_pop = agt_rdvalid && !q_empty;

  memtest_issue #(.N_WORDS(N_WORDS), .DEPTH(DEPTH)) u_issue (
    .clk(clk), .rst_n(rst_n), .start(start), .done_i(done),
    .agt_wait(agt_wait), .q_count(q_count), .q_pop(q_pop),
    .req_active(req_active), .req_wr(req_wr), .req_idx(req_idx),
    .start_acc(start_acc), .rd_acc(rd_acc)
  );

  memtest_tagq #(.W(IDX_W), .DEPTH(DEPTH)) u_tagq (
    .clk(clk), .rst_n(rst_n), .push(rd_acc), .din(req_idx),
    .pop(q_pop), .head(head_idx), .count(q_count), .empty(q_empty)
  );

  memtest_check #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_WORDS(N_WORDS)) u_check (
    .clk(clk), .rst_n(rst_n), .clear(start_acc), .pop(q_pop),
    .head_idx(head_idx), .rdata(agt_rdata),
    .done(done), .fail(fail), .fail_addr(fail_addr)
  );

  always_comb begin
    agt_addr  = ADDR_W'(req_idx);
    agt_wdata = req_wr ? DATA_W'(req_idx) : '0;
    agt_wr_n  = !(req_active && req_wr);
    agt_rd_n  = !(req_active && !req_wr);
    agt_cs    = req_active;
    agt_be_n  = '0;
    pass      = done && !fail;
  end
endmodule

// File: rtl/memtest_host_chk.sv
module memtest_host_chk #(
  parameter int ADDR_W = 25,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  localparam int BE_W  = DATA_W / 8,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic [ADDR_W-1:0] agt_addr,
  input logic [DATA_W-1:0] agt_wdata,
  input logic              agt_rd_n,
  input logic              agt_wr_n,
  input logic              agt_cs,
  input logic [BE_W-1:0]   agt_be_n,
  input logic              agt_wait,
  input logic              done,
  input logic              pass,
  input logic              fail,
  input logic [ADDR_W-1:0] fail_addr,
  input logic [CNT_W-1:0]  q_count
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (agt_rd_n && agt_wr_n && !agt_cs && !done && !fail));
  // R2
  byte_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agt_be_n == '0);
  // R4
  hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (agt_cs && agt_wait) |=> (agt_cs && $stable(agt_addr) && $stable(agt_wdata)
                              && $stable(agt_rd_n) && $stable(agt_wr_n)));
  // R5
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!agt_rd_n && !agt_wr_n));
  // R5
  cs_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    agt_cs == (!agt_rd_n || !agt_wr_n));
  // R7
  outstanding_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    q_count <= CNT_W'(DEPTH));
  // R8
  fail_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fail && !start) |=> (fail && $stable(fail_addr)));
  // R9
  pass_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));
  // R9
  pass_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> done);
endmodule

bind memtest_host memtest_host_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .agt_addr(agt_addr),
  .agt_wdata(agt_wdata), .agt_rd_n(agt_rd_n), .agt_wr_n(agt_wr_n),
  .agt_cs(agt_cs), .agt_be_n(agt_be_n), .agt_wait(agt_wait),
  .done(done), .pass(pass), .fail(fail), .fail_addr(fail_addr),
  .q_count(q_count)
);

// File: tb/tb_memtest_host.sv
`timescale 1ns/1ps
module tb_memtest_host;
  localparam int AW = 25, DW = 16, NW = 8, DP = 4;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [AW-1:0] agt_addr, fail_addr;
  logic [DW-1:0] agt_wdata, agt_rdata;
  logic agt_rd_n, agt_wr_n, agt_cs, agt_wait, agt_rdvalid;
  logic [1:0] agt_be_n;
  logic done, pass, fail;

  always #2.5 clk = ~clk;

  memtest_host #(.ADDR_W(AW), .DATA_W(DW), .N_WORDS(NW), .DEPTH(DP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .agt_addr(agt_addr),
    .agt_wdata(agt_wdata), .agt_rd_n(agt_rd_n), .agt_wr_n(agt_wr_n),
    .agt_cs(agt_cs), .agt_be_n(agt_be_n), .agt_wait(agt_wait),
    .agt_rdata(agt_rdata), .agt_rdvalid(agt_rdvalid), .done(done),
    .pass(pass), .fail(fail), .fail_addr(fail_addr)
  );

  int n_chk = 0, n_bad = 0, cycles = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- slave model ----------------
  int cfg_ww = 0, cfg_rw = 0, cfg_lat = 1;
  logic [7:0] bad_mask = '0;
  logic stray = 1'b0;
  logic [DW-1:0] mem [16];
  logic vpipe [8];
  logic [DW-1:0] dpipe [8];
  int wcnt = 0;
  int n_wr, n_rd, outst, max_outst, order_err, hold_err, excl_err;
  logic p_hold; logic [AW-1:0] p_addr; logic [DW-1:0] p_wdata; logic p_rd_n, p_wr_n;

  assign agt_wait    = (wcnt != 0);
  assign agt_rdvalid = vpipe[0] | stray;
  assign agt_rdata   = vpipe[0] ? dpipe[0] : 16'hFFFF;

  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      wcnt <= 0; p_hold <= 1'b0;
      for (int k = 0; k < 8; k++) begin vpipe[k] <= 1'b0; dpipe[k] <= '0; end
    end else begin
      if (p_hold && (!agt_cs || agt_addr != p_addr || agt_wdata != p_wdata ||
                     agt_rd_n != p_rd_n || agt_wr_n != p_wr_n)) hold_err++;
      if ((!agt_rd_n && !agt_wr_n) || (agt_cs != (!agt_rd_n || !agt_wr_n))) excl_err++;
      p_hold <= agt_cs && agt_wait; p_addr <= agt_addr; p_wdata <= agt_wdata;
      p_rd_n <= agt_rd_n; p_wr_n <= agt_wr_n;
      for (int k = 0; k < 7; k++) begin vpipe[k] <= vpipe[k+1]; dpipe[k] <= dpipe[k+1]; end
      vpipe[7] <= 1'b0;
      if (vpipe[0]) outst--;
      if (agt_cs && !agt_wait) begin
        if (!agt_wr_n) begin
          if (agt_addr != AW'(n_wr) || agt_be_n != 2'b00) order_err++;
          mem[agt_addr[3:0]] <= agt_wdata;
          n_wr++;
          wcnt <= cfg_ww;
        end else begin
          if (agt_addr != AW'(n_rd)) order_err++;
          n_rd++; outst++;
          vpipe[cfg_lat-1] <= 1'b1;
          dpipe[cfg_lat-1] <= mem[agt_addr[3:0]] ^ (bad_mask[agt_addr[2:0]] ? 16'h0100 : 16'h0000);
          wcnt <= cfg_rw;
        end
      end else if (agt_cs && wcnt > 0) begin
        wcnt <= wcnt - 1;
      end
      if (outst > max_outst) max_outst = outst;
    end
  end

  // watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  function automatic int first_bad(logic [7:0] m);
    for (int i = 0; i < 8; i++) if (m[i]) return i;
    return 0;
  endfunction

  task automatic run_one(int ww, int rw, int lat, logic [7:0] mask, bit mid_start, int want_max);
    int t;
    bit ok;
    @(negedge clk);
    cfg_ww = ww; cfg_rw = rw; cfg_lat = lat; bad_mask = mask;
    n_wr = 0; n_rd = 0; outst = 0; max_outst = 0; order_err = 0; hold_err = 0; excl_err = 0;
    for (int i = 0; i < 16; i++) mem[i] = 16'hDEAD;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R1 / R10: write strobe low the cycle after start, status cleared
    chk(!agt_wr_n && !done && !fail, "R10", "start clears status, begins write", {agt_wr_n, done, fail}, 3'b000);
    t = 0;
    while (!done && t < 3000) begin
      @(negedge clk); t++;
      if (mid_start && t == 5) start = 1'b1;
      else start = 1'b0;
    end
    start = 1'b0;
    chk(done, "R9", "done reached", done, 1);
    chk(pass == (mask == 0) && fail == (mask != 0), "R9", "pass/fail", {pass, fail},
        {mask == 0, mask != 0});
    if (mask != 0)
      chk(fail_addr == AW'(first_bad(mask)), "R8", "first failing address", fail_addr, first_bad(mask));
    chk(n_wr == NW && order_err == 0, "R2", "write count/order", n_wr * 256 + order_err, NW * 256);
    ok = 1;
    for (int i = 0; i < NW; i++) if (mem[i] != DW'(i)) ok = 0;
    chk(ok, "R2", "written pattern", ok, 1);
    chk(n_rd == NW, "R3", "read count", n_rd, NW);
    chk(hold_err == 0, "R4", "request held under wait", hold_err, 0);
    chk(excl_err == 0, "R5", "strobe/chipselect relation", excl_err, 0);
    chk(max_outst <= DP, "R7", "outstanding limit", max_outst, DP);
    if (want_max > 0) chk(max_outst == want_max, "R7", "pipelined reads reach depth", max_outst, want_max);
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'h0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    chk(agt_rd_n && agt_wr_n && !agt_cs && !done && !pass && !fail, "R1", "reset state",
        {agt_rd_n, agt_wr_n, agt_cs, done, pass, fail}, 6'b110000);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R3 R4 R9: wait-length / latency sweep, clean memory
    for (int ww = 0; ww < 4; ww++)
      for (int rw = 0; rw < 4; rw++)
        for (int l = 0; l < 4; l++)
          run_one(ww, rw, (l == 3) ? 6 : l + 1, 8'h00, 0, 0);

    // R7: slow responses with no wait fill the read queue
    run_one(0, 0, 6, 8'h00, 0, DP);

    // R8: every corruption pattern
    for (int m = 1; m < 256; m++) run_one(m % 3, (m / 3) % 2, 1 + m % 4, 8'(m), 0, 0);

    // R10: start during a pass is ignored
    run_one(1, 1, 2, 8'h00, 1, 0);

    // R6: stray read-valid after done leaves status alone
    @(negedge clk); stray = 1'b1;
    @(negedge clk); stray = 1'b0;
    @(negedge clk);
    chk(done && pass && !fail, "R6", "stray read-valid ignored", {done, pass, fail}, 3'b110);

    // R10: fail then clean pass clears fail
    run_one(0, 0, 2, 8'h10, 0, 0);
    run_one(0, 0, 2, 8'h00, 0, 0);

    // R1: reset in the middle of a pass
    @(negedge clk); cfg_ww = 2; cfg_rw = 0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(agt_rd_n && agt_wr_n && !agt_cs && !done, "R1", "mid-pass reset idles",
        {agt_rd_n, agt_wr_n, agt_cs, done}, 4'b1100);
    rst_n = 1'b1;
    run_one(0, 1, 3, 8'h00, 0, 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule